// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block receives a serial data stream that arrives with an external bit clock and frame-sync signal. It turns that stream into parallel words. All three serial inputs are brought into the system clock domain through a short synchronizer. The block then detects the selected bit-clock edge and samples data and frame sync on that edge. A frame begins on the inactive-to-active transition of frame sync. After a programmable delay of zero, one or two sampling edges, the block shifts in the elements of one phase or of two phases. Each phase has its own element count and its own word length.

Each finished word is right-justified in a one-word output register, and `word_valid_o` is raised for it. The register stays valid until `word_ack_i` takes the word. Two conditions produce one-cycle flags. The first is a word that completes while the previous word is still untaken, which is an overrun. The second is a frame sync edge that arrives while a frame is in progress, which is unexpected.

Control state machine:
- States: `ST_IDLE` (waiting for a frame), `ST_DELAY` (counting delay edges) and `ST_SHIFT` (capturing bits).
- `ST_IDLE` → `ST_DELAY` on a frame start when the delay is not zero.
- `ST_IDLE` → `ST_SHIFT` on a frame start when the delay is zero. The bit on that edge is captured.
- `ST_DELAY` → `ST_SHIFT` when the delay count runs out. The bit on that edge is captured.
- `ST_SHIFT` → `ST_IDLE` after the last bit of the last element of the last phase.
- `ST_SHIFT` → `ST_DELAY` when a frame sync edge coincides with that final bit and the delay is not zero. This starts the next frame back to back.

Top module: `rx_framed_word`

## Requirements
- R1: Words are assembled MSB first and right-justified, with zeros above the word. The word-length codes are: 000 = 8 bits, 001 = 12, 010 = 16, 011 = 20, 100 = 24, 101 = 32. Codes 110 and 111 are treated as 32.
- R2: A phase carries (count field + 1) elements, so the count field 0..127 gives 1 to 128 elements.
- R3: With `cfg_dual_i` = 1, phase 0 uses `cfg_cnt0_i`/`cfg_wlen0_i` and phase 1 then uses `cfg_cnt1_i`/`cfg_wlen1_i`. With `cfg_dual_i` = 0, only phase 0 is received.
- R4: The delay code d (0, 1 or 2; code 3 acts as 2) places the first data bit d sampling edges after the edge on which frame sync is first seen active.
- R5: With `cfg_clk_pol_i` = 0, data and frame sync are sampled on falling bit-clock edges. With `cfg_clk_pol_i` = 1, they are sampled on rising edges.
- R6: With `cfg_fs_pol_i` = 0, frame sync is active high. With `cfg_fs_pol_i` = 1, it is active low.
- R7: A word is bit-reversed over all 32 bits only when three conditions hold together: `cfg_rev_i` = 1, `cfg_comp_i` = 01, and the word length code of the current phase is 101. Otherwise the word is kept in received order.
- R8: `word_valid_o` rises in the cycle after a word completes. It stays high, with `word_o` stable, until a cycle with `word_ack_i` high.
- R9: When a word completes while `word_valid_o` is high and `word_ack_i` is low, `overrun_o` pulses for one cycle. The new word replaces the old one.
- R10: After the final word of a frame, data is ignored until the next frame sync edge.
- R11: A frame sync edge during a frame pulses `unexp_sync_o` and leaves the frame unchanged. An edge on the final bit of a frame is the exception when the delay is not zero: it starts the next frame instead.
- R12: After reset, `word_valid_o`, `overrun_o` and `unexp_sync_o` are low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data |
| cfg_dual_i | input | 1 | Enable two-phase frames |
| cfg_cnt0_i | input | 7 | Phase 0 element count minus one |
| cfg_cnt1_i | input | 7 | Phase 1 element count minus one |
| cfg_wlen0_i | input | 3 | Phase 0 word length code |
| cfg_wlen1_i | input | 3 | Phase 1 word length code |
| cfg_dly_i | input | 2 | Data delay in sampling edges |
| cfg_clk_pol_i | input | 1 | Sampling edge select (0 = falling) |
| cfg_fs_pol_i | input | 1 | Frame sync polarity (0 = active high) |
| cfg_rev_i | input | 1 | Bit reversal enable |
| cfg_comp_i | input | 2 | Companding mode field (01 permits reversal) |
| word_ack_i | input | 1 | Takes the current output word |
| word_o | output | 32 | Received word, right-justified |
| word_valid_o | output | 1 | Output word is valid |
| overrun_o | output | 1 | One-cycle pulse: untaken word overwritten |
| unexp_sync_o | output | 1 | One-cycle pulse: frame sync during a frame |

## Verification
The bench sends frames with mixed phase layouts, all three delays, both edge and polarity choices, and reversal settings that only partly agree. A design that miscounted the delay would return every word shifted by one bit. A design that reversed on the enable alone would scramble the word whose companding field is not 01. The bench also sends a frame sync in mid-frame and a frame sync coincident with the final bit. A receiver that restarted on the first would lose words, and one that flagged the second would drop the following frame. The remaining cases are bits sent after a frame ends, which must yield no word, and an untaken word, which must raise overrun while keeping the newest data.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

    localparam int BIT_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    // Word length code to number of bits per element.
    function automatic logic [BIT_W-1:0] wlen_bits(input logic [2:0] code);
        logic [BIT_W-1:0] n;
        unique case (code)
            3'b000:  n = 6'd8;
            3'b001:  n = 6'd12;
            3'b010:  n = 6'd16;
            3'b011:  n = 6'd20;
            3'b100:  n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rxfr_sample.sv
module rxfr_sample #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic sdata_i,
    input  logic cfg_clk_pol,
    input  logic cfg_fs_pol,
    output logic sample_en,
    output logic bit_o,
    output logic fs_start
);
    // {bclk, fsync, sdata}
    logic [2:0] synced;
    logic       bclk_prev;
    logic       fs_prev;
    logic       fs_act;

    generate
        if (SYNC_STAGES <= 1) begin : g_one
            logic [2:0] stage;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= '0;
                else        stage <= {bclk_i, fsync_i, sdata_i};
            end
            assign synced = stage;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0][2:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], {bclk_i, fsync_i, sdata_i}};
            end
            assign synced = chain[SYNC_STAGES-1];
        end
    endgenerate

    assign sample_en = (synced[2] != bclk_prev) && (synced[2] == cfg_clk_pol);
    assign fs_act    = synced[1] ^ cfg_fs_pol;
    assign bit_o     = synced[0];
    assign fs_start  = sample_en && fs_act && !fs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
            fs_prev   <= 1'b0;
        end else begin
            bclk_prev <= synced[2];
            if (sample_en) fs_prev <= fs_act;
        end
    end

endmodule

// File: rtl/rxfr_ctrl.sv
module rxfr_ctrl
    import rxfr_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int DLY_W   = 2,
    parameter int DLY_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             fs_start,
    input  logic             cfg_dual,
    input  logic [CNT_W-1:0] cfg_cnt0,
    input  logic [CNT_W-1:0] cfg_cnt1,
    input  logic [2:0]       cfg_wlen0,
    input  logic [2:0]       cfg_wlen1,
    input  logic [DLY_W-1:0] cfg_dly,
    output logic             capture,
    output logic             first_bit,
    output logic             word_done,
    output logic [2:0]       cur_wlen,
    output logic             unexp_o
);
    rx_state_e        state, state_n;
    logic             phase, phase_n;
    logic [CNT_W-1:0] elem, elem_n;
    logic [BIT_W-1:0] bitcnt, bitcnt_n;
    logic [DLY_W-1:0] dcnt, dcnt_n;

    logic [DLY_W-1:0] dly_eff;
    logic [BIT_W-1:0] nbits;
    logic             bit_last, elem_last, phase_last;
    logic             frame_end, restart, unexp_n;

    assign dly_eff    = (cfg_dly > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : cfg_dly;
    assign cur_wlen   = phase ? cfg_wlen1 : cfg_wlen0;
    assign nbits      = wlen_bits(cur_wlen);
    assign bit_last   = (bitcnt == nbits - 1'b1);
    assign elem_last  = (elem == (phase ? cfg_cnt1 : cfg_cnt0));
    assign phase_last = phase || !cfg_dual;

    always_comb begin
        capture = 1'b0;
        if (sample_en) begin
            unique case (state)
                ST_IDLE:  capture = fs_start && (dly_eff == '0);
                ST_DELAY: capture = (dcnt == '0);
                ST_SHIFT: capture = 1'b1;
                default:  capture = 1'b0;
            endcase
        end
    end

    assign first_bit = capture && (bitcnt == '0);
    assign word_done = capture && bit_last;
    assign frame_end = word_done && elem_last && phase_last;
    assign restart   = fs_start && ((state == ST_IDLE) || (frame_end && dly_eff != '0));
    assign unexp_n   = fs_start && !restart;

    // Next-state logic
    always_comb begin
        state_n  = state;
        phase_n  = phase;
        elem_n   = elem;
        bitcnt_n = bitcnt;
        dcnt_n   = dcnt;
        if (state == ST_DELAY && sample_en && dcnt != '0)
            dcnt_n = dcnt - 1'b1;
        if (capture) begin
            state_n = ST_SHIFT;
            if (bit_last) begin
                bitcnt_n = '0;
                if (elem_last) begin
                    elem_n = '0;
                    if (phase_last) begin
                        phase_n = 1'b0;
                        state_n = ST_IDLE;
                    end else begin
                        phase_n = 1'b1;
                    end
                end else begin
                    elem_n = elem + 1'b1;
                end
            end else begin
                bitcnt_n = bitcnt + 1'b1;
            end
        end
        if (restart && dly_eff != '0) begin
            state_n = ST_DELAY;
            dcnt_n  = dly_eff - 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= 1'b0;
            elem   <= '0;
            bitcnt <= '0;
            dcnt   <= '0;
        end else begin
            state  <= state_n;
            phase  <= phase_n;
            elem   <= elem_n;
            bitcnt <= bitcnt_n;
            dcnt   <= dcnt_n;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unexp_o <= 1'b0;
        else        unexp_o <= unexp_n;
    end

    p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!phase && elem == '0 && bitcnt == '0));
    p_bit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (bitcnt < nbits));
    p_single_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dual |-> !phase);
    p_unexp_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unexp_o |-> ($past(state) != ST_IDLE));

endmodule

// File: rtl/rxfr_word.sv
module rxfr_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         first_bit,
    input  logic         word_done,
    input  logic         bit_i,
    input  logic         rev_sel,
    input  logic         ack_i,
    output logic [W-1:0] word_o,
    output logic         valid_o,
    output logic         overrun_o
);
    logic [W-1:0] sr;
    logic [W-1:0] word_next;
    logic [W-1:0] word_rev;

    assign word_next = first_bit ? {{(W-1){1'b0}}, bit_i} : {sr[W-2:0], bit_i};

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign word_rev[i] = word_next[W-1-i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            word_o    <= '0;
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            if (capture) sr <= word_next;
            if (word_done) word_o <= rev_sel ? word_rev : word_next;
            if (word_done)   valid_o <= 1'b1;
            else if (ack_i)  valid_o <= 1'b0;
            overrun_o <= word_done && valid_o && !ack_i;
        end
    end

    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(word_o)) || $past(word_done));
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i && !word_done) |=> !valid_o);
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ($past(valid_o) && valid_o));

endmodule

// File: rtl/rx_framed_word.sv
module rx_framed_word
    import rxfr_pkg::*;
#(
    parameter int W           = 32,
    parameter int CNT_W       = 7,
    parameter int DLY_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fsync_i,
    input  logic             sdata_i,
    input  logic             cfg_dual_i,
    input  logic [CNT_W-1:0] cfg_cnt0_i,
    input  logic [CNT_W-1:0] cfg_cnt1_i,
    input  logic [2:0]       cfg_wlen0_i,
    input  logic [2:0]       cfg_wlen1_i,
    input  logic [DLY_W-1:0] cfg_dly_i,
    input  logic             cfg_clk_pol_i,
    input  logic             cfg_fs_pol_i,
    input  logic             cfg_rev_i,
    input  logic [1:0]       cfg_comp_i,
    input  logic             word_ack_i,
    output logic [W-1:0]     word_o,
    output logic             word_valid_o,
    output logic             overrun_o,
    output logic             unexp_sync_o
);
    localparam logic [2:0] REV_WLEN = 3'b101;
    localparam logic [1:0] REV_COMP = 2'b01;

    logic       sample_en, bit_s, fs_start;
    logic       capture, first_bit, word_done;
    logic [2:0] cur_wlen;
    logic       rev_sel;

    rxfr_sample #(.SYNC_STAGES(SYNC_STAGES)) u_sample (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk_i),
        .fsync_i     (fsync_i),
        .sdata_i     (sdata_i),
        .cfg_clk_pol (cfg_clk_pol_i),
        .cfg_fs_pol  (cfg_fs_pol_i),
        .sample_en   (sample_en),
        .bit_o       (bit_s),
        .fs_start    (fs_start)
    );

    rxfr_ctrl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .fs_start  (fs_start),
        .cfg_dual  (cfg_dual_i),
        .cfg_cnt0  (cfg_cnt0_i),
        .cfg_cnt1  (cfg_cnt1_i),
        .cfg_wlen0 (cfg_wlen0_i),
        .cfg_wlen1 (cfg_wlen1_i),
        .cfg_dly   (cfg_dly_i),
        .capture   (capture),
        .first_bit (first_bit),
        .word_done (word_done),
        .cur_wlen  (cur_wlen),
        .unexp_o   (unexp_sync_o)
    );

    assign rev_sel = cfg_rev_i && (cfg_comp_i == REV_COMP) && (cur_wlen == REV_WLEN);

    rxfr_word #(.W(W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .first_bit (first_bit),
        .word_done (word_done),
        .bit_i     (bit_s),
        .rev_sel   (rev_sel),
        .ack_i     (word_ack_i),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .overrun_o (overrun_o)
    );

    p_flags_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!word_valid_o && !overrun_o && !unexp_sync_o));

endmodule

// File: tb/rx_framed_word_tb.sv
module rx_framed_word_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic        dual = 1'b0;
    logic [6:0]  cnt0 = '0, cnt1 = '0;
    logic [2:0]  wl0 = '0, wl1 = '0;
    logic [1:0]  dly = 2'd1;
    logic        cp = 1'b0, fp = 1'b0, rev = 1'b0;
    logic [1:0]  comp = '0;
    logic        auto_ack = 1'b1;
    logic        ack;
    logic [31:0] word;
    logic        valid, ovr, unexp;

    int n_tests = 0, n_fail = 0;
    int ovr_cnt = 0, unexp_cnt = 0;
    logic [31:0] got[$];
    logic        fsq[$];
    logic        dq[$];

    always #5 clk = ~clk;

    assign ack = auto_ack && valid;

    rx_framed_word u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
        .cfg_dual_i(dual), .cfg_cnt0_i(cnt0), .cfg_cnt1_i(cnt1),
        .cfg_wlen0_i(wl0), .cfg_wlen1_i(wl1), .cfg_dly_i(dly),
        .cfg_clk_pol_i(cp), .cfg_fs_pol_i(fp), .cfg_rev_i(rev), .cfg_comp_i(comp),
        .word_ack_i(ack), .word_o(word), .word_valid_o(valid),
        .overrun_o(ovr), .unexp_sync_o(unexp)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid && auto_ack) got.push_back(word);
            if (ovr)   ovr_cnt++;
            if (unexp) unexp_cnt++;
        end
    end

    typedef struct packed {
        logic             dual;
        logic [6:0]       c0, c1;
        logic [2:0]       wl0, wl1;
        logic [1:0]       dly;
        logic             cp, fp, rev;
        logic [1:0]       comp;
        logic [3:0][31:0] din;   // '{w3,w2,w1,w0}
        logic [3:0][31:0] dexp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        // R1 R4 8-bit word, delay 1, falling edge, active-high sync
        '{1'b0, 7'd0, 7'd0, 3'b000, 3'b000, 2'd1, 1'b0, 1'b0, 1'b0, 2'b00,
          '{32'h0, 32'h0, 32'h0, 32'h0000_00A5}, '{32'h0, 32'h0, 32'h0, 32'h0000_00A5}},
        // R2 R5 three 16-bit words, delay 0, rising edge
        '{1'b0, 7'd2, 7'd0, 3'b010, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 2'b00,
          '{32'h0, 32'h0F0F, 32'hABCD, 32'h1234}, '{32'h0, 32'h0F0F, 32'hABCD, 32'h1234}},
        // R3 R6 dual phase 8 then 2x12, delay 2, active-low sync
        '{1'b1, 7'd0, 7'd1, 3'b000, 3'b001, 2'd2, 1'b0, 1'b1, 1'b0, 2'b00,
          '{32'h0, 32'h123, 32'hABC, 32'h3C}, '{32'h0, 32'h123, 32'hABC, 32'h3C}},
        // R7 all three settings agree: reversed
        '{1'b0, 7'd0, 7'd0, 3'b101, 3'b000, 2'd1, 1'b0, 1'b0, 1'b1, 2'b01,
          '{32'h0, 32'h0, 32'h0, 32'h1234_5678}, '{32'h0, 32'h0, 32'h0, 32'h1E6A_2C48}},
        // R7 companding field 00: not reversed
        '{1'b0, 7'd0, 7'd0, 3'b101, 3'b000, 2'd1, 1'b0, 1'b0, 1'b1, 2'b00,
          '{32'h0, 32'h0, 32'h0, 32'h1234_5678}, '{32'h0, 32'h0, 32'h0, 32'h1234_5678}},
        // R1 R4 R5 R6 24-bit, delay code 3, rising edge, active low
        '{1'b0, 7'd0, 7'd0, 3'b100, 3'b000, 2'd3, 1'b1, 1'b1, 1'b0, 2'b00,
          '{32'h0, 32'h0, 32'h0, 32'hC0FFEE}, '{32'h0, 32'h0, 32'h0, 32'hC0FFEE}},
        // R3 R7 dual: 2x20 plain, then 32 reversed in phase 1 only
        '{1'b1, 7'd1, 7'd0, 3'b011, 3'b101, 2'd1, 1'b0, 1'b0, 1'b1, 2'b01,
          '{32'h0, 32'h3, 32'h5A5A5, 32'hABCDE}, '{32'h0, 32'hC000_0000, 32'h5A5A5, 32'hABCDE}}
    };

    function automatic int wbits(input logic [2:0] c);
        case (c)
            3'b000:  return 8;
            3'b001:  return 12;
            3'b010:  return 16;
            3'b011:  return 20;
            3'b100:  return 24;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic set_cfg(input vec_t v);
        @(negedge clk);
        dual = v.dual; cnt0 = v.c0; cnt1 = v.c1; wl0 = v.wl0; wl1 = v.wl1;
        dly = v.dly; cp = v.cp; fp = v.fp; rev = v.rev; comp = v.comp;
        repeat (2) @(negedge clk);
        bclk = ~cp; fsync = fp; sdata = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic drive_slot(input logic fs_act, input logic d);
        bclk = ~cp; fsync = fs_act ^ fp; sdata = d;
        repeat (4) @(negedge clk);
        bclk = cp;
        repeat (4) @(negedge clk);
    endtask

    task automatic play();
        for (int s = 0; s < fsq.size(); s++) drive_slot(fsq[s], dq[s]);
        fsync = fp;
        repeat (10) @(negedge clk);
        fsq.delete(); dq.delete();
    endtask

    task automatic push_word(input logic [31:0] w, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            fsq.push_back(1'b0); dq.push_back(w[b]);
        end
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) begin
            fsq.push_back(1'b0); dq.push_back(1'b0);
        end
    endtask

    // Frame sync on slot 0, data starting d slots later
    task automatic build_frame(input vec_t v);
        int nw, de;
        nw = v.c0 + 1 + (v.dual ? v.c1 + 1 : 0);
        de = (v.dly == 2'd3) ? 2 : int'(v.dly);
        if (de == 0) begin
            // first data bit shares the sync slot
        end else begin
            fsq.push_back(1'b1); dq.push_back(1'b0);
            push_idle(de - 1);
        end
        for (int k = 0; k < nw; k++)
            push_word(v.din[k], wbits((k <= int'(v.c0)) ? v.wl0 : v.wl1));
        if (de == 0) fsq[0] = 1'b1;
        push_idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        vec_t v;
        int nw;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid",   {31'b0, valid}, 32'h0);
        chk("R12 overrun", {31'b0, ovr},   32'h0);
        chk("R12 unexp",   {31'b0, unexp}, 32'h0);
        chk("R12 word",    word,           32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: R1-style cases, each row tagged in its comment
        for (int r = 0; r < NV; r++) begin
            v = VEC[r];
            set_cfg(v);
            got.delete(); unexp_cnt = 0;
            build_frame(v);
            play();
            nw = v.c0 + 1 + (v.dual ? v.c1 + 1 : 0);
            chk($sformatf("R2 word count row %0d", r), got.size(), nw);
            for (int k = 0; k < nw; k++)
                chk($sformatf("R1 R3 R7 word %0d row %0d", k, r),
                    (k < got.size()) ? got[k] : 32'hDEAD_BEEF, v.dexp[k]);
            chk($sformatf("R11 no unexp row %0d", r), unexp_cnt, 0);
        end

        // R10: bits after the frame with no sync produce nothing
        v = VEC[0];
        set_cfg(v);
        got.delete();
        build_frame(v);
        push_word(32'hFFFF_FFFF, 24);
        play();
        chk("R10 idle words", got.size(), 1);
        chk("R10 frame word", (got.size() > 0) ? got[0] : 32'hDEAD_BEEF, 32'hA5);

        // R11: sync in mid-frame flagged, frame unaffected
        v = VEC[0]; v.c0 = 7'd1;
        set_cfg(v);
        got.delete(); unexp_cnt = 0;
        fsq.push_back(1'b1); dq.push_back(1'b0);
        push_word(32'h5C, 8);
        push_word(32'h93, 8);
        push_idle(3);
        fsq[5] = 1'b1;
        play();
        chk("R11 unexp pulses", unexp_cnt, 1);
        chk("R11 word count", got.size(), 2);
        chk("R11 word0", (got.size() > 0) ? got[0] : 32'hDEAD_BEEF, 32'h5C);
        chk("R11 word1", (got.size() > 1) ? got[1] : 32'hDEAD_BEEF, 32'h93);

        // R11: sync on the final bit with delay 1 starts the next frame
        v = VEC[0];
        set_cfg(v);
        got.delete(); unexp_cnt = 0;
        fsq.push_back(1'b1); dq.push_back(1'b0);
        push_word(32'h81, 8);
        fsq[8] = 1'b1;
        push_word(32'h7E, 8);
        push_idle(3);
        play();
        chk("R11 back-to-back unexp", unexp_cnt, 0);
        chk("R11 back-to-back count", got.size(), 2);
        chk("R11 back-to-back word1", (got.size() > 1) ? got[1] : 32'hDEAD_BEEF, 32'h7E);

        // R8 R9: untaken word overwritten, overrun pulses once
        v = VEC[0]; v.c0 = 7'd1;
        set_cfg(v);
        got.delete(); ovr_cnt = 0;
        auto_ack = 1'b0;
        fsq.push_back(1'b1); dq.push_back(1'b0);
        push_word(32'h11, 8);
        push_word(32'h22, 8);
        push_idle(3);
        play();
        chk("R9 overrun pulses", ovr_cnt, 1);
        chk("R8 valid held", {31'b0, valid}, 32'h1);
        chk("R9 newest word", word, 32'h22);
        @(negedge clk);
        auto_ack = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 valid cleared by ack", {31'b0, valid}, 32'h0);

        summary();
    end

endmodule